// File: doc/BRIEF.md
# Packed element blend unit

This block merges two 128-bit vectors word by word. For each element it either takes the element from a source vector or keeps the element of the old destination value. The choice comes from one of two places. An immediate byte can supply it, one bit per element. Otherwise a mask vector supplies it, using the top (sign) bit of each of its elements. Elements are 64 bits wide in two of the variants and 32 bits wide in the other two.

The variant is chosen by decoding a raw four-byte opcode string that arrives with the operands. A single valid strobe qualifies each request. The merged vector appears one clock later together with an output valid flag. An opcode string that matches none of the four variants raises an illegal flag, and the old destination value is returned unchanged. Element contents are treated as raw bits. No arithmetic and no exception logic touches them.

Top module: `blend_unit`

## Requirements
- R1: While reset is active, and after it until the first strobe, `outValid`, `illegalOp` and `result` are all zero.
- R2: `outValid` is high in exactly the cycle after a cycle with `inValid` high. `illegalOp` is only ever high together with `outValid`.
- R3: `opBytes` holds the first opcode byte in [31:24] and the last in [7:0]. The legal encodings are: 0x660F3A0D for 64-bit immediate, 0x660F3A0C for 32-bit immediate, 0x660F3815 for 64-bit variable, and 0x660F3814 for 32-bit variable.
- R4: In 64-bit immediate mode, `immByte` bit 0 selects bits [63:0] and bit 1 selects bits [127:64]. Immediate bits [7:2] have no effect.
- R5: In 32-bit immediate mode, `immByte` bit n selects bits [32n+31:32n] for n = 0..3. Immediate bits [7:4] have no effect.
- R6: In 64-bit variable mode, `maskVec` bit 63 selects the low half and bit 127 selects the high half. All other mask bits have no effect.
- R7: In 32-bit variable mode, `maskVec` bit 32n+31 selects bits [32n+31:32n]. All other mask bits have no effect.
- R8: A selecting bit of 1 puts the source element into `result`, and a 0 keeps the old destination element. Every bit pattern, including NaN, denormal and negative encodings, passes through unaltered.
- R9: An opcode outside R3 gives `illegalOp` = 1 and `result` equal to `oldDst` in the cycle after the strobe.
- R10: While `inValid` is low, `result` holds its last value, and the operand inputs have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request strobe |
| opBytes | input | 32 | Raw opcode byte string, first byte in the top byte |
| immByte | input | 8 | Immediate mask byte |
| oldDst | input | 128 | Previous destination value |
| srcVec | input | 128 | Source vector |
| maskVec | input | 128 | Variable mask vector, sign bit per element |
| outValid | output | 1 | Result valid, one cycle after the strobe |
| illegalOp | output | 1 | Opcode matched no variant |
| result | output | 128 | Merged destination value |

## Verification
A fault in a lane select appears at the ports as one or two 32-bit words of `result` taken from the wrong operand. It is visible in the very cycle that `outValid` rises for the request that exposes it. A fault in the decoder appears as a wrong element width, a wrong mask source or a false `illegalOp` on that same cycle. Because of this, every request is compared whole against a bench model as soon as it returns. The requests cover all sixteen low immediate patterns, with noise in the ignored immediate bits and in the non-sign mask bits.

// File: rtl/blend_pkg.sv
package blend_pkg;
  typedef enum logic [1:0] {
    VAR_IMM_WIDE   = 2'd0,
    VAR_IMM_NARROW = 2'd1,
    VAR_MSK_WIDE   = 2'd2,
    VAR_MSK_NARROW = 2'd3
  } blendVariant_e;

  // strobes from control to datapath
  typedef struct packed {
    logic legal;   // opcode recognised
    logic useImm;  // selector from immediate byte, else from mask sign bits
    logic narrow;  // 32-bit elements, else 64-bit
  } blendCtrl_t;

  localparam logic [31:0] OPC_IMM_WIDE   = 32'h660F_3A0D;
  localparam logic [31:0] OPC_IMM_NARROW = 32'h660F_3A0C;
  localparam logic [31:0] OPC_MSK_WIDE   = 32'h660F_3815;
  localparam logic [31:0] OPC_MSK_NARROW = 32'h660F_3814;
endpackage

// File: rtl/blend_ctrl.sv
module blend_ctrl
  import blend_pkg::*;
#(
  parameter int OPC_W = 32
) (
  input  logic [OPC_W-1:0] opBytes,
  output blendCtrl_t       ctrl
);
  blendVariant_e variant;
  logic          hit;

  always_comb begin
    hit     = 1'b1;
    variant = VAR_IMM_WIDE;
    unique case (opBytes)
      OPC_IMM_WIDE:   variant = VAR_IMM_WIDE;
      OPC_IMM_NARROW: variant = VAR_IMM_NARROW;
      OPC_MSK_WIDE:   variant = VAR_MSK_WIDE;
      OPC_MSK_NARROW: variant = VAR_MSK_NARROW;
      default:        hit = 1'b0;
    endcase
  end

  always_comb begin
    ctrl.legal  = hit;
    ctrl.useImm = (variant == VAR_IMM_WIDE) || (variant == VAR_IMM_NARROW);
    ctrl.narrow = (variant == VAR_IMM_NARROW) || (variant == VAR_MSK_NARROW);
  end
endmodule

// File: rtl/blend_datapath.sv
module blend_datapath
  import blend_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 32,
  parameter int IMM_W  = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  blendCtrl_t       ctrl,
  input  logic [IMM_W-1:0] immByte,
  input  logic [VEC_W-1:0] oldDst,
  input  logic [VEC_W-1:0] srcVec,
  input  logic [VEC_W-1:0] maskVec,
  output logic [VEC_W-1:0] result,
  output logic             outValid,
  output logic             illegalOp
);
  localparam int LANES  = VEC_W / LANE_W;
  localparam int WIDE_W = 2 * LANE_W;

  logic [VEC_W-1:0] nextVec;
  logic [LANES-1:0] takeSrc;
  logic             unusedBits;

  // only the element sign bits and low immediate bits steer lanes
  assign unusedBits = ^{maskVec, immByte};

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int PAIR = k / 2;
    logic narrowImm, wideImm, narrowVar, wideVar, pick;
    assign narrowImm = immByte[k];
    assign wideImm   = immByte[PAIR];
    assign narrowVar = maskVec[k*LANE_W + LANE_W - 1];
    assign wideVar   = maskVec[PAIR*WIDE_W + WIDE_W - 1];
    always_comb begin
      if (ctrl.useImm) pick = ctrl.narrow ? narrowImm : wideImm;
      else             pick = ctrl.narrow ? narrowVar : wideVar;
    end
    assign takeSrc[k] = ctrl.legal & pick;
    assign nextVec[k*LANE_W +: LANE_W] =
      takeSrc[k] ? srcVec[k*LANE_W +: LANE_W] : oldDst[k*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result    <= '0;
      outValid  <= 1'b0;
      illegalOp <= 1'b0;
    end else begin
      outValid  <= inValid;
      illegalOp <= inValid & ~ctrl.legal;
      if (inValid) result <= nextVec;
    end
  end
endmodule

// File: rtl/blend_unit.sv
module blend_unit
  import blend_pkg::*;
#(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 32,
  parameter int IMM_W  = 8,
  parameter int OPC_W  = 32
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [OPC_W-1:0] opBytes,
  input  logic [IMM_W-1:0] immByte,
  input  logic [VEC_W-1:0] oldDst,
  input  logic [VEC_W-1:0] srcVec,
  input  logic [VEC_W-1:0] maskVec,
  output logic             outValid,
  output logic             illegalOp,
  output logic [VEC_W-1:0] result
);
  blendCtrl_t ctrl;

  blend_ctrl #(.OPC_W(OPC_W)) ctrl_i (
    .opBytes(opBytes),
    .ctrl   (ctrl)
  );

  blend_datapath #(.VEC_W(VEC_W), .LANE_W(LANE_W), .IMM_W(IMM_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .ctrl     (ctrl),
    .immByte  (immByte),
    .oldDst   (oldDst),
    .srcVec   (srcVec),
    .maskVec  (maskVec),
    .result   (result),
    .outValid (outValid),
    .illegalOp(illegalOp)
  );
endmodule

// File: rtl/blend_unit_chk.sv
module blend_unit_chk #(
  parameter int VEC_W  = 128,
  parameter int LANE_W = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic [VEC_W-1:0] oldDst,
  input logic [VEC_W-1:0] srcVec,
  input logic             outValid,
  input logic             illegalOp,
  input logic [VEC_W-1:0] result
);
  localparam int LANES = VEC_W / LANE_W;

  // R2
  outvalid_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> outValid);
  // R2
  outvalid_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> !outValid);
  // R2
  illegal_with_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    illegalOp |-> outValid);
  // R9
  illegal_keeps_old_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid ##1 illegalOp |-> result == $past(oldDst));
  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(result));

  for (genvar k = 0; k < LANES; k++) begin : g_lane_chk
    // R8
    lane_source_chk: assert property (@(posedge clk) disable iff (!rstN)
      inValid ##1 outValid |->
        (result[k*LANE_W +: LANE_W] == $past(oldDst[k*LANE_W +: LANE_W])) ||
        (result[k*LANE_W +: LANE_W] == $past(srcVec[k*LANE_W +: LANE_W])));
  end
endmodule

bind blend_unit blend_unit_chk #(.VEC_W(VEC_W), .LANE_W(LANE_W)) chk_i (
  .clk(clk), .rstN(rstN), .inValid(inValid), .oldDst(oldDst), .srcVec(srcVec),
  .outValid(outValid), .illegalOp(illegalOp), .result(result)
);

// File: tb/blend_unit_tb_top.sv
module blend_unit_tb_top;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         inValid = 1'b0;
  logic [31:0]  opBytes = '0;
  logic [7:0]   immByte = '0;
  logic [127:0] oldDst = '0, srcVec = '0, maskVec = '0;
  logic         outValid, illegalOp;
  logic [127:0] result;
  int errors = 0;
  int checks = 0;

  localparam logic [31:0] OP_IW = 32'h660F3A0D;
  localparam logic [31:0] OP_IN = 32'h660F3A0C;
  localparam logic [31:0] OP_MW = 32'h660F3815;
  localparam logic [31:0] OP_MN = 32'h660F3814;

  always #10 clk = ~clk; // 50 MHz

  blend_unit dut_i (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opBytes(opBytes),
    .immByte(immByte), .oldDst(oldDst), .srcVec(srcVec), .maskVec(maskVec),
    .outValid(outValid), .illegalOp(illegalOp), .result(result)
  );

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  function automatic logic [127:0] refBlend(input logic [31:0] op, input logic [7:0] imm,
                                            input logic [127:0] o, s, m);
    logic [127:0] r;
    r = o;
    case (op)
      OP_IW: for (int q = 0; q < 2; q++) if (imm[q]) r[q*64 +: 64] = s[q*64 +: 64];
      OP_IN: for (int w = 0; w < 4; w++) if (imm[w]) r[w*32 +: 32] = s[w*32 +: 32];
      OP_MW: for (int q = 0; q < 2; q++) if (m[q*64+63]) r[q*64 +: 64] = s[q*64 +: 64];
      OP_MN: for (int w = 0; w < 4; w++) if (m[w*32+31]) r[w*32 +: 32] = s[w*32 +: 32];
      default: ;
    endcase
    return r;
  endfunction

  function automatic bit isLegal(input logic [31:0] op);
    return op == OP_IW || op == OP_IN || op == OP_MW || op == OP_MN;
  endfunction

  task automatic check(input string tag, input logic [129:0] got, input logic [129:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic runOp(input string tag, input logic [31:0] op, input logic [7:0] imm,
                       input logic [127:0] o, s, m);
    logic [129:0] exp;
    exp = {1'b1, !isLegal(op), refBlend(op, imm, o, s, m)};
    opBytes = op; immByte = imm; oldDst = o; srcVec = s; maskVec = m; inValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    check(tag, {outValid, illegalOp, result}, exp);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : stim
    logic [127:0] last, o, s;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset", {outValid, illegalOp, result}, '0);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 after reset", {outValid, illegalOp, result}, '0);

    // R4 R5: all 16 low immediate patterns, noise in ignored high bits
    for (int p = 0; p < 16; p++) begin
      runOp("R4 imm64", OP_IW, {$urandom_range(0, 15), p[3:0]}, rnd128(), rnd128(), rnd128());
      runOp("R5 imm32", OP_IN, {$urandom_range(0, 15), p[3:0]}, rnd128(), rnd128(), rnd128());
    end
    // R4 R5 directed: high bits only, must select nothing
    runOp("R4 high imm ignored", OP_IW, 8'hFC, rnd128(), rnd128(), '0);
    runOp("R5 high imm ignored", OP_IN, 8'hF0, rnd128(), rnd128(), '0);

    // R6 R7: all 16 sign-bit patterns, random other mask bits
    for (int p = 0; p < 16; p++) begin
      logic [127:0] m;
      m = rnd128();
      for (int w = 0; w < 4; w++) m[w*32+31] = p[w];
      runOp("R6 var64", OP_MW, $urandom_range(0, 255), rnd128(), rnd128(), m);
      runOp("R7 var32", OP_MN, $urandom_range(0, 255), rnd128(), rnd128(), m);
    end
    runOp("R6 non-sign ignored", OP_MW, 8'hFF, rnd128(), rnd128(), ~(128'h1 << 63 | 128'h1 << 127));
    runOp("R7 non-sign ignored", OP_MN, 8'hFF, rnd128(), rnd128(), 128'h7FFFFFFF_7FFFFFFF_7FFFFFFF_7FFFFFFF);

    // R8: special floating-point bit patterns pass unaltered
    s = {64'h7FF8_0000_0000_0001, 32'h8000_0001, 32'hFFC0_0000};
    o = {64'h8000_0000_0000_0000, 32'h0000_0001, 32'h7F80_0000};
    runOp("R8 raw bits wide", OP_IW, 8'h02, o, s, '0);
    runOp("R8 raw bits narrow", OP_IN, 8'h05, o, s, '0);
    runOp("R8 all source", OP_MN, 8'h00, o, s, {4{32'h8000_0000}});

    // R3 R9: near-miss and random opcodes
    runOp("R9 illegal 3A0E", 32'h660F3A0E, 8'hFF, rnd128(), rnd128(), '1);
    runOp("R9 illegal 3816", 32'h660F3816, 8'hFF, rnd128(), rnd128(), '1);
    runOp("R3 prefix mismatch", 32'h670F3A0C, 8'hFF, rnd128(), rnd128(), '1);
    for (int i = 0; i < 20; i++)
      runOp("R9 random opcode", $urandom, $urandom_range(0, 255), rnd128(), rnd128(), rnd128());

    // R3: random mix of all variants
    for (int i = 0; i < 200; i++) begin
      logic [31:0] op;
      case ($urandom_range(0, 3))
        0: op = OP_IW; 1: op = OP_IN; 2: op = OP_MW; default: op = OP_MN;
      endcase
      runOp("R3 mixed", op, $urandom_range(0, 255), rnd128(), rnd128(), rnd128());
    end

    // R2 R10: idle cycles with changing operands
    last = result;
    opBytes = OP_IN; immByte = 8'hFF; oldDst = rnd128(); srcVec = rnd128(); maskVec = '1;
    @(posedge clk);
    @(negedge clk);
    check("R2 idle no valid", {outValid, illegalOp}, 2'b00);
    srcVec = ~srcVec;
    @(posedge clk);
    @(negedge clk);
    check("R10 hold", result, last);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule